// File: doc/BRIEF.md
# Interrupt Request Masking and Flag Stage

This block is the front end of a small controller's interrupt system. It gathers five request sources: two active-low external lines, two timer overflow events and a serial port flag. It holds an enable register with one mask bit per source and a master enable bit. It reports the requests that survive masking as a pending vector, plus a single selected source picked in a fixed order.

Timer overflows arrive as one-cycle pulses. Each pulse sets a flag in the cycle of the overflow. The request logic sees that flag only one cycle later. When the CPU side acknowledges a timer request, the block clears that timer's flag. The serial flag belongs to the serial port: the block never clears it. The external lines are level-sensitive and pass through a two-stage synchroniser before use.

Top module: `irq_mask_stage`

## Requirements
- R1: While reset is asserted and directly after it is released, the enable register reads 0x00, and the pending vector, request, selected index and timer flags are all 0.
- R2: A write stores data bits 7 and 4..0 into the enable register, which reads back on `cfg_rdata` from the next cycle. Bits 6 and 5 always read 0, whatever is written.
- R3: Source numbering is external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. Pending bit i is set only when the source is requesting, enable bit i is 1 and enable bit 7 is 1.
- R4: While enable bit 7 is 0, the pending vector is zero and `irq_req` is low. Timer flags are still set and kept.
- R5: An external input driven low appears in the pending vector after two clock edges. Returning it high removes it after two clock edges.
- R6: An overflow pulse sampled at an edge sets that timer's flag (`tmr_flag`) at that edge. The pending bit follows one edge later.
- R7: A timer flag stays set until an acknowledge is given while that timer is the selected source. The flag and its pending bit are cleared at the acknowledging edge.
- R8: The serial request follows `ser_flag` with one edge of delay and is not cleared by an acknowledge.
- R9: `irq_id` gives the lowest-numbered pending source (numbering as in R3). `irq_req` is high when any pending bit is set. `irq_id` is 0 when nothing is pending.
- R10: If an overflow and an acknowledge of the same timer fall on the same edge, the flag remains set.
- R11: An acknowledge with no request, or one that selects a non-timer source, leaves both timer flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_irq_n | input | 2 | Active-low external request lines (bit 0 = external 0) |
| tmr_ovf | input | 2 | One-cycle timer overflow pulses (bit 0 = timer 0) |
| ser_flag | input | 1 | Serial port request flag, cleared by software at its source |
| cfg_wr | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable register write data |
| cfg_rdata | output | 8 | Enable register read data |
| irq_ack | input | 1 | Acknowledge of the currently selected source |
| tmr_flag | output | 2 | Timer overflow flags |
| irq_pend | output | 5 | Masked pending vector, indexed by source number |
| irq_req | output | 1 | Any source pending |
| irq_id | output | 3 | Selected source index |

## Verification
The assertions assume that an overflow is a single-cycle pulse. They also assume that `irq_ack` is acted on only against the `irq_id` shown in that same cycle, and that the inputs are stable around the rising edge. The bench drives every input just after a falling edge. It holds each random overflow for one cycle only and draws the acknowledge freely, so that acknowledges with no request, and acknowledges that coincide with overflows, both occur within those bounds.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC     = 5;
  localparam int unsigned IDW      = 3;
  localparam int unsigned REGW     = 8;
  localparam int unsigned GEN_BIT  = 7;
  localparam logic [REGW-1:0] IMPL_MASK = 8'h9F;

  localparam logic [IDW-1:0] SRC_EXT0 = 3'd0;
  localparam logic [IDW-1:0] SRC_TMR0 = 3'd1;
  localparam logic [IDW-1:0] SRC_EXT1 = 3'd2;
  localparam logic [IDW-1:0] SRC_TMR1 = 3'd3;
  localparam logic [IDW-1:0] SRC_SER  = 3'd4;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = d_i;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_tflag.sv
module irq_tflag #(
  parameter int unsigned NTMR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTMR-1:0] ovf_i,
  input  logic [NTMR-1:0] clr_i,
  output logic [NTMR-1:0] flag_o,
  output logic [NTMR-1:0] samp_o
);
  logic [NTMR-1:0] flag_q, flag_d;
  logic [NTMR-1:0] samp_q, samp_d;

  always_comb begin
    flag_d = ovf_i | (flag_q & ~clr_i);
    samp_d = flag_q & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      samp_q <= '0;
    end else begin
      flag_q <= flag_d;
      samp_q <= samp_d;
    end
  end

  assign flag_o = flag_q;
  assign samp_o = samp_q;

  genvar t;
  generate
    for (t = 0; t < NTMR; t++) begin : g_chk
      // R6: an overflow sets the flag at the same edge
      a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i[t] |=> flag_q[t]);
      // R6: the sampled copy only rises after the flag was already up
      a_r6_sample_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_q[t]) |-> $past(flag_q[t]));
      // R7: a clear without a coinciding overflow drops the flag
      a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[t] && !ovf_i[t]) |=> !flag_q[t]);
      // R10: a coinciding overflow keeps the flag
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[t] && ovf_i[t]) |=> flag_q[t]);
    end
  endgenerate
endmodule

// File: rtl/irq_enreg.sv
module irq_enreg
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [REGW-1:0] wdata_i,
  output logic [REGW-1:0] rdata_o
);
  logic [REGW-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign rdata_o = en_q;

  // R2: written data reads back with unimplemented positions forced low
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (rdata_o == {$past(wdata_i[7]), 2'b00, $past(wdata_i[4:0])}));
  // R2: without a write the register holds its value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
(
  input  src_vec_t       pend_i,
  output src_vec_t       grant_o,
  output logic [IDW-1:0] id_o,
  output logic           any_o
);
  always_comb begin
    grant_o = '0;
    id_o    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        id_o = IDW'(i);
      end
    end
    any_o = |pend_i;
  end

  // R9: at most one source is granted, and only when something is pending
  a_r9_grant_onehot: assert final ($onehot0(grant_o));
  a_r9_grant_any: assert final (any_o == (grant_o != '0));
endmodule

// File: rtl/irq_mask_stage.sv
module irq_mask_stage
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_irq_n,
  input  logic [1:0]  tmr_ovf,
  input  logic        ser_flag,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        irq_ack,
  output logic [1:0]  tmr_flag,
  output logic [4:0]  irq_pend,
  output logic        irq_req,
  output logic [2:0]  irq_id
);
  logic [1:0]      ext_sync_n;
  logic [1:0]      ext_act;
  logic [1:0]      tmr_samp;
  logic [1:0]      tmr_clr;
  logic            ser_q, ser_d;
  logic [REGW-1:0] en_reg;
  src_vec_t        raw_req;
  src_vec_t        pend_vec;
  src_vec_t        grant;
  logic [IDW-1:0]  sel_id;
  logic            sel_any;

  irq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_irq_n),
    .q_o   (ext_sync_n)
  );

  assign ext_act = ~ext_sync_n;

  irq_enreg u_enreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cfg_wr),
    .wdata_i (cfg_wdata),
    .rdata_o (en_reg)
  );

  irq_tflag #(.NTMR(2)) u_tflag (
    .clk    (clk),
    .rst_n  (rst_n),
    .ovf_i  (tmr_ovf),
    .clr_i  (tmr_clr),
    .flag_o (tmr_flag),
    .samp_o (tmr_samp)
  );

  always_comb ser_d = ser_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_q <= 1'b0;
    else        ser_q <= ser_d;
  end

  always_comb begin
    raw_req           = '0;
    raw_req[SRC_EXT0] = ext_act[0];
    raw_req[SRC_TMR0] = tmr_samp[0];
    raw_req[SRC_EXT1] = ext_act[1];
    raw_req[SRC_TMR1] = tmr_samp[1];
    raw_req[SRC_SER]  = ser_q;
    pend_vec = raw_req & en_reg[NSRC-1:0] & {NSRC{en_reg[GEN_BIT]}};
  end

  irq_select u_sel (
    .pend_i  (pend_vec),
    .grant_o (grant),
    .id_o    (sel_id),
    .any_o   (sel_any)
  );

  always_comb begin
    tmr_clr[0] = irq_ack & grant[SRC_TMR0];
    tmr_clr[1] = irq_ack & grant[SRC_TMR1];
  end

  assign cfg_rdata = en_reg;
  assign irq_pend  = pend_vec;
  assign irq_req   = sel_any;
  assign irq_id    = sel_id;

  // R9: the selected index always points at a pending source
  a_r9_id_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_pend[irq_id]);
  // R4: master enable low leaves nothing pending
  a_r4_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |-> (irq_pend == '0 && !irq_req));
  // R11: an acknowledge with nothing pending keeps the timer flags
  a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && tmr_ovf == 2'b00) |=> $stable(tmr_flag));
  // R8: the serial pending bit survives an acknowledge while the flag stays high
  a_r8_ser_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_pend[4] && ser_flag && !cfg_wr) |=> irq_pend[4]);
endmodule

// File: tb/tb_irq_mask_stage.sv
module tb_irq_mask_stage;
  logic       clk;
  logic       rst_n;
  logic [1:0] ext_irq_n;
  logic [1:0] tmr_ovf;
  logic       ser_flag;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       irq_ack;
  logic [1:0] tmr_flag;
  logic [4:0] irq_pend;
  logic       irq_req;
  logic [2:0] irq_id;

  int checks;
  int failures;

  irq_mask_stage dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
    .ser_flag(ser_flag), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_ack(irq_ack), .tmr_flag(tmr_flag),
    .irq_pend(irq_pend), .irq_req(irq_req), .irq_id(irq_id)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference state, built from the requirements
  logic [7:0] m_en;
  logic [1:0] m_s1, m_s2;
  logic [1:0] m_tf, m_tfs;
  logic       m_ser;

  function automatic logic [4:0] exp_pend(input logic [7:0] en, input logic [1:0] ext,
                                          input logic [1:0] tfs, input logic ser);
    logic [4:0] raw;
    raw = {ser, tfs[1], ext[1], tfs[0], ext[0]};
    return en[7] ? (raw & en[4:0]) : 5'd0;
  endfunction

  function automatic logic [2:0] exp_id(input logic [4:0] p);
    for (int i = 0; i < 5; i++) if (p[i]) return 3'(i);
    return 3'd0;
  endfunction

  logic [4:0] m_pend;
  always_comb m_pend = exp_pend(m_en, m_s2, m_tfs, m_ser);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 8'h00; m_s1 <= 2'b00; m_s2 <= 2'b00;
      m_tf <= 2'b00; m_tfs <= 2'b00; m_ser <= 1'b0;
    end else begin
      logic [1:0] clr;
      clr = 2'b00;
      if (irq_ack && m_pend != 5'd0) begin
        if (exp_id(m_pend) == 3'd1) clr[0] = 1'b1;
        if (exp_id(m_pend) == 3'd3) clr[1] = 1'b1;
      end
      if (cfg_wr) m_en <= {cfg_wdata[7], 2'b00, cfg_wdata[4:0]};
      m_s1  <= ~ext_irq_n;
      m_s2  <= m_s1;
      m_tf  <= tmr_ovf | (m_tf & ~clr);
      m_tfs <= m_tf & ~clr;
      m_ser <= ser_flag;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    checks = 0; failures = 0;
    rst_n = 1'b0; ext_irq_n = 2'b11; tmr_ovf = 2'b00; ser_flag = 1'b0;
    cfg_wr = 1'b0; cfg_wdata = 8'h00; irq_ack = 1'b0;
    repeat (3) tick();
    check("R1 rdata in reset", cfg_rdata, 8'h00);
    check("R1 pend in reset", irq_pend, 5'd0);
    rst_n = 1'b1;
    tick();
    check("R1 rdata", cfg_rdata, 8'h00);
    check("R1 pend", irq_pend, 5'd0);
    check("R1 req", irq_req, 1'b0);
    check("R1 id", irq_id, 3'd0);
    check("R1 tflag", tmr_flag, 2'b00);

    wr_en(8'hFF);
    check("R2 unimpl bits", cfg_rdata, 8'h9F);
    wr_en(8'h60);
    check("R2 only unimpl written", cfg_rdata, 8'h00);

    // R5 external level path
    wr_en(8'h81);
    ext_irq_n = 2'b10;
    tick();
    check("R5 one edge not yet", irq_pend, 5'd0);
    tick();
    check("R5 ext0 pending", irq_pend, 5'b00001);
    check("R9 id ext0", irq_id, 3'd0);
    check("R9 req", irq_req, 1'b1);
    ext_irq_n = 2'b11;
    tick();
    check("R5 release one edge", irq_pend, 5'b00001);
    tick();
    check("R5 release done", irq_pend, 5'd0);

    // R6/R7 timer 0
    wr_en(8'h82);
    tmr_ovf = 2'b01;
    tick();
    tmr_ovf = 2'b00;
    check("R6 flag set", tmr_flag, 2'b01);
    check("R6 pend delayed", irq_pend, 5'd0);
    tick();
    check("R6 pend", irq_pend, 5'b00010);
    check("R9 id tmr0", irq_id, 3'd1);
    repeat (3) tick();
    check("R7 flag held", tmr_flag, 2'b01);
    check("R7 pend held", irq_pend, 5'b00010);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R7 flag cleared", tmr_flag, 2'b00);
    check("R7 pend cleared", irq_pend, 5'd0);

    // R4/R3/R10 timer 1
    wr_en(8'h08);
    tmr_ovf = 2'b10;
    tick();
    tmr_ovf = 2'b00;
    check("R4 flag set while off", tmr_flag, 2'b10);
    tick();
    check("R4 nothing pending", irq_pend, 5'd0);
    check("R4 no req", irq_req, 1'b0);
    wr_en(8'h88);
    check("R3 tmr1 enabled", irq_pend, 5'b01000);
    check("R9 id tmr1", irq_id, 3'd3);
    irq_ack = 1'b1; tmr_ovf = 2'b10;
    tick();
    irq_ack = 1'b0; tmr_ovf = 2'b00;
    check("R10 set wins", tmr_flag, 2'b10);
    tick();
    check("R10 pend again", irq_pend, 5'b01000);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R7 tmr1 cleared", tmr_flag, 2'b00);

    // R8 serial
    wr_en(8'h90);
    ser_flag = 1'b1;
    tick();
    check("R8 ser pend", irq_pend, 5'b10000);
    check("R9 id ser", irq_id, 3'd4);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R8 ser kept after ack", irq_pend, 5'b10000);
    ser_flag = 1'b0;
    tick();
    check("R8 ser follows flag", irq_pend, 5'd0);

    // R9 ordering, R11 non-timer ack
    wr_en(8'h9F);
    ext_irq_n = 2'b00; tmr_ovf = 2'b11; ser_flag = 1'b1;
    tick();
    tmr_ovf = 2'b00;
    tick();
    check("R9 all pending", irq_pend, 5'b11111);
    check("R9 ext0 first", irq_id, 3'd0);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R11 ext ack keeps tflags", tmr_flag, 2'b11);
    ext_irq_n = 2'b11;
    tick(); tick();
    check("R9 remaining", irq_pend, 5'b11010);
    check("R9 tmr0 next", irq_id, 3'd1);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R7 only tmr0 cleared", tmr_flag, 2'b10);
    check("R9 tmr1 next", irq_id, 3'd3);
    ser_flag = 1'b0;

    // R11 ack with nothing pending
    wr_en(8'h00);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R11 idle ack", tmr_flag, 2'b10);
    wr_en(8'h1F);
    check("R4 master off", irq_pend, 5'd0);
    check("R11 flags kept", tmr_flag, 2'b10);

    // constrained random phase against the reference
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0) ext_irq_n = 2'($urandom);
      tmr_ovf  = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      if ($urandom_range(0, 5) == 0) ser_flag = ~ser_flag;
      cfg_wr    = ($urandom_range(0, 7) == 0);
      cfg_wdata = 8'($urandom);
      irq_ack   = ($urandom_range(0, 3) == 0);
      tick();
      check("R2 random rdata", cfg_rdata, m_en);
      check("R3 random pend", irq_pend, m_pend);
      check("R9 random id", irq_id, exp_id(m_pend));
      check("R9 random req", irq_req, m_pend != 5'd0);
      check("R6 random tflag", tmr_flag, m_tf);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule